// File: doc/BRIEF.md
# Interrupt Redirection Register File with Indirect Access

This block holds the software-visible state of an I/O interrupt controller. A CPU reaches every internal register through two address windows. A select register holds an index. A data window reads or writes the 32-bit register that the index names. Behind the window are an identification register, a read-only version register and a redirection table with one 64-bit entry per interrupt input. Each entry is reached as a lower half and an upper half. A third address takes a direct end-of-interrupt (EOI) write, and only the newer controller version accepts it.

The delivery logic beside this block reads the whole table from a flat export bus. It reports two per-pin status conditions back through dedicated inputs: the in-flight (busy) indication and the set and clear requests for the remote-IRR flag. Software can read both status bits but cannot write them. Each entry write emits a one-cycle per-pin pulse that clears that pin's storm counter in the delivery logic. An accepted EOI write emits a one-cycle strobe with the written vector.

The block has no state machine. Every register updates on a single clock edge, and reads are combinational from the address and the current select value.

Top module: `irr_regs`

## Requirements
- R1: After reset the select register reads 0, the ID field reads 0, and every table entry equals 0x0000_0000_0001_0000, which means masked (bit 16) with all other bits zero.
- R2: A write to address 0x00 loads the select index from wdata[7:0], and a read of 0x00 returns it zero-extended. A read or write at address 0x10 reaches the register named by the select index. Any other address reads 0.
- R3: A select of 0x10 or above addresses entry (select − 0x10) >> 1. An odd select reaches entry bits 63:32 and an even select reaches bits 31:0. The other half of the entry is left unchanged by the write.
- R4: A select that is neither 0x00, 0x01 nor a valid entry reads 0 through the window, and writes to it change no register and raise no storm-clear pulse. A valid entry is one whose computed number is below the pin count, so with 24 pins selects 0x40 and above and 0x02 to 0x0F are in this class.
- R5: Index 0x01 reads {8'h00, PINS−1, 8'h00, VERSION}: the version code in bits 7:0 and the highest entry number in bits 23:16. Writes to it have no effect.
- R6: Index 0x00 returns the stored 4-bit ID in bits 27:24 with all other bits zero. A write stores only wdata[27:24].
- R7: Entry bits 12 (busy) and 14 (remote IRR) are read-only to software and keep their values across writes to either half. Bit 12 takes hw_busy one cycle later. Bit 14 is set by hw_rirr_set, and hw_rirr_clr clears it with priority over the set.
- R8: When an entry write leaves the trigger-mode bit 15 at 0 (edge), that entry's bit 14 becomes 0 at the same edge, whatever its earlier value or a coincident hw_rirr_set.
- R9: Each entry write raises storm_clr[n] for exactly one cycle, in the cycle after the write, and for that entry only.
- R10: With VERSION 0x20, a write to address 0x40 with bus_word=1 raises eoi_valid for one cycle in the next cycle, with eoi_vector equal to wdata[7:0]. With bus_word=0, or with VERSION 0x11, no strobe is produced.
- R11: tbl_flat[n*64 +: 64] always equals the current 64-bit value of entry n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address: 0x00 select, 0x10 data window, 0x40 EOI |
| bus_wdata | input | 32 | Write data |
| bus_word | input | 1 | 1 when the access is a full 4-byte access |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| hw_rirr_set | input | PINS | Per-pin request to set remote IRR |
| hw_rirr_clr | input | PINS | Per-pin request to clear remote IRR |
| hw_busy | input | PINS | Per-pin busy status, copied into bit 12 |
| tbl_flat | output | PINS*64 | All table entries, entry n at bits n*64+63 : n*64 |
| storm_clr | output | PINS | One-cycle per-pin storm-counter clear |
| eoi_valid | output | 1 | One-cycle EOI strobe |
| eoi_vector | output | 8 | Vector carried by the EOI strobe |

## Verification
The hardest state to reach from the ports is an entry whose remote-IRR bit is set. Software cannot write that bit, so the stimulus first puts the entry in level mode through the window and then pulses hw_rirr_set. Two checks follow. The first rewrites a half of the entry and confirms the bit survives. The second rewrites the entry with bit 15 clear and confirms the bit drops. The busy bit is reached the same way by holding hw_busy for a cycle before the read. The EOI gating is checked against a second instance built with the older version code.

// File: rtl/irr_pkg.sv
package irr_pkg;
    localparam logic [7:0] ADDR_SEL = 8'h00;
    localparam logic [7:0] ADDR_WIN = 8'h10;
    localparam logic [7:0] ADDR_EOI = 8'h40;

    localparam logic [7:0] IDX_ID   = 8'h00;
    localparam logic [7:0] IDX_VER  = 8'h01;
    localparam logic [7:0] TBL_BASE = 8'h10;

    localparam int B_BUSY = 12;
    localparam int B_RIRR = 14;
    localparam int B_TRIG = 15;
    localparam int B_MASK = 16;

    localparam logic [63:0] RO_BITS   = (64'd1 << B_BUSY) | (64'd1 << B_RIRR);
    localparam logic [63:0] ENTRY_RST = 64'd1 << B_MASK;

    localparam int ID_SHIFT = 24;
    localparam int ID_W     = 4;

    typedef enum logic [1:0] {
        TGT_ID,
        TGT_VER,
        TGT_ENT,
        TGT_NONE
    } tgt_e;
endpackage

// File: rtl/irr_decode.sv
module irr_decode
    import irr_pkg::*;
#(
    parameter int PINS = 24,
    parameter int IW   = $clog2(PINS)
) (
    input  logic [7:0]    sel,
    output tgt_e          kind,
    output logic [IW-1:0] idx,
    output logic          upper
);
    logic [7:0] off;
    logic       in_tbl;

    assign off    = sel - TBL_BASE;
    assign in_tbl = (sel >= TBL_BASE) && ({1'b0, off[7:1]} < 8'(PINS));
    assign upper  = sel[0];
    assign idx    = off[IW:1];

    always_comb begin
        if (sel == IDX_ID)       kind = TGT_ID;
        else if (sel == IDX_VER) kind = TGT_VER;
        else if (in_tbl)         kind = TGT_ENT;
        else                     kind = TGT_NONE;
    end
endmodule

// File: rtl/irr_entry.sv
module irr_entry
    import irr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic        upper,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    input  logic        rirr_clr,
    input  logic        busy,
    output logic [63:0] entry
);
    logic [63:0] merged;
    logic [63:0] nxt;
    logic        rirr_hw;

    assign merged  = upper ? {wdata, entry[31:0]} : {entry[63:32], wdata};
    assign rirr_hw = (entry[B_RIRR] | rirr_set) & ~rirr_clr;

    always_comb begin
        if (wr) begin
            nxt         = merged & ~RO_BITS;
            nxt[B_RIRR] = merged[B_TRIG] ? rirr_hw : 1'b0;
        end else begin
            nxt         = entry;
            nxt[B_RIRR] = rirr_hw;
        end
        nxt[B_BUSY] = busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) entry <= ENTRY_RST;
        else        entry <= nxt;
    end
endmodule

// File: rtl/irr_regs.sv
module irr_regs
    import irr_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h20,
    parameter int         PINS    = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_word,
    output logic [31:0]        bus_rdata,
    input  logic [PINS-1:0]    hw_rirr_set,
    input  logic [PINS-1:0]    hw_rirr_clr,
    input  logic [PINS-1:0]    hw_busy,
    output logic [PINS*64-1:0] tbl_flat,
    output logic [PINS-1:0]    storm_clr,
    output logic               eoi_valid,
    output logic [7:0]         eoi_vector
);
    localparam int         IW     = $clog2(PINS);
    localparam logic [7:0] MAX_IX = 8'(PINS - 1);

    logic [7:0]      sel_q;
    logic [ID_W-1:0] id_q;
    tgt_e            kind;
    logic [IW-1:0]   idx;
    logic            upper;
    logic            win_wr;
    logic [PINS-1:0] ent_wr;
    logic [63:0]     ent_q [PINS];

    irr_decode #(.PINS(PINS), .IW(IW)) u_dec (
        .sel   (sel_q),
        .kind  (kind),
        .idx   (idx),
        .upper (upper)
    );

    assign win_wr = bus_we && (bus_addr == ADDR_WIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
        end else begin
            if (bus_we && bus_addr == ADDR_SEL) sel_q <= bus_wdata[7:0];
            if (win_wr && kind == TGT_ID)       id_q  <= bus_wdata[ID_SHIFT +: ID_W];
        end
    end

    for (genvar n = 0; n < PINS; n++) begin : g_ent
        assign ent_wr[n] = win_wr && (kind == TGT_ENT) && (idx == IW'(n));
        irr_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (ent_wr[n]),
            .upper    (upper),
            .wdata    (bus_wdata),
            .rirr_set (hw_rirr_set[n]),
            .rirr_clr (hw_rirr_clr[n]),
            .busy     (hw_busy[n]),
            .entry    (ent_q[n])
        );
        assign tbl_flat[n*64 +: 64] = ent_q[n];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) storm_clr <= '0;
        else        storm_clr <= ent_wr;
    end

    if (VERSION == 8'h20) begin : g_eoi
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                eoi_valid  <= 1'b0;
                eoi_vector <= '0;
            end else begin
                eoi_valid <= bus_we && bus_word && (bus_addr == ADDR_EOI);
                if (bus_we && bus_word && bus_addr == ADDR_EOI)
                    eoi_vector <= bus_wdata[7:0];
            end
        end
    end else begin : g_no_eoi
        assign eoi_valid  = 1'b0;
        assign eoi_vector = '0;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_SEL) begin
            bus_rdata = {24'd0, sel_q};
        end else if (bus_addr == ADDR_WIN) begin
            unique case (kind)
                TGT_ID:   bus_rdata = 32'(id_q) << ID_SHIFT;
                TGT_VER:  bus_rdata = {8'h00, MAX_IX, 8'h00, VERSION};
                TGT_ENT:  bus_rdata = upper ? ent_q[idx][63:32] : ent_q[idx][31:0];
                TGT_NONE: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irr_regs_chk.sv
module irr_regs_chk
    import irr_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h20,
    parameter int         PINS    = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [7:0]         bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               bus_word,
    input logic [PINS-1:0]    hw_rirr_set,
    input logic [PINS-1:0]    hw_rirr_clr,
    input logic [PINS*64-1:0] tbl_flat,
    input logic [PINS-1:0]    storm_clr,
    input logic               eoi_valid,
    input logic [7:0]         eoi_vector
);
    p_storm_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(storm_clr));

    p_storm_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr != ADDR_WIN |=> storm_clr == '0);

    p_eoi_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_word && bus_addr == ADDR_EOI) |=> !eoi_valid);

    p_eoi_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_word && bus_addr == ADDR_EOI && VERSION == 8'h20
        |=> eoi_valid && eoi_vector == $past(bus_wdata[7:0]));

    always_comb begin
        if (rst_n && VERSION != 8'h20)
            p_eoi_old_ver_r10: assert (!eoi_valid);
    end

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        p_edge_rirr_r8: assert property (@(posedge clk) disable iff (!rst_n)
            storm_clr[n] && !tbl_flat[n*64 + B_TRIG] |-> !tbl_flat[n*64 + B_RIRR]);

        p_rirr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            hw_rirr_set[n] && !hw_rirr_clr[n] |=> tbl_flat[n*64 + B_RIRR] || storm_clr[n]);

        p_rirr_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
            hw_rirr_clr[n] |=> !tbl_flat[n*64 + B_RIRR]);
    end
endmodule

bind irr_regs irr_regs_chk #(.VERSION(VERSION), .PINS(PINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_word    (bus_word),
    .hw_rirr_set (hw_rirr_set),
    .hw_rirr_clr (hw_rirr_clr),
    .tbl_flat    (tbl_flat),
    .storm_clr   (storm_clr),
    .eoi_valid   (eoi_valid),
    .eoi_vector  (eoi_vector)
);

// File: tb/sim_irr_regs.sv
module sim_irr_regs;
    localparam int PINS = 24;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_we = 1'b0;
    logic [7:0]         bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic               bus_word = 1'b1;
    logic [31:0]        rdata, rdata_old;
    logic [PINS-1:0]    rset = '0, rclr = '0, busy = '0;
    logic [PINS*64-1:0] tbl, tbl_old;
    logic [PINS-1:0]    sclr, sclr_old;
    logic               ev, ev_old;
    logic [7:0]         evec, evec_old;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irr_regs #(.VERSION(8'h20), .PINS(PINS)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_word(bus_word), .bus_rdata(rdata),
        .hw_rirr_set(rset), .hw_rirr_clr(rclr), .hw_busy(busy),
        .tbl_flat(tbl), .storm_clr(sclr), .eoi_valid(ev), .eoi_vector(evec)
    );

    irr_regs #(.VERSION(8'h11), .PINS(PINS)) u_old (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_word(bus_word), .bus_rdata(rdata_old),
        .hw_rirr_set(rset), .hw_rirr_clr(rclr), .hw_busy(busy),
        .tbl_flat(tbl_old), .storm_clr(sclr_old), .eoi_valid(ev_old), .eoi_vector(evec_old)
    );

    // {select, write data, expected readback}
    localparam logic [71:0] VEC [8] = '{
        {8'h10, 32'h0000_A031, 32'h0000_A031},  // R3 entry 0 low
        {8'h11, 32'hFF00_0000, 32'hFF00_0000},  // R3 entry 0 high
        {8'h2F, 32'h1234_5678, 32'h1234_5678},  // R3 entry 15 high
        {8'h3E, 32'h0001_5A42, 32'h0001_0A42},  // R7 status bits dropped
        {8'h40, 32'hFFFF_FFFF, 32'h0000_0000},  // R4 past last entry
        {8'h01, 32'h0000_0000, 32'h0017_0020},  // R5 version
        {8'h00, 32'hFFFF_FFFF, 32'h0F00_0000},  // R6 id field only
        {8'h05, 32'hFFFF_FFFF, 32'h0000_0000}   // R4 unmapped index
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic full);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_word = full;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = rdata;
    endtask

    task automatic win_rd(input logic [7:0] s, output logic [31:0] d);
        wr(8'h00, {24'd0, s}, 1'b1);
        rd(8'h10, d);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, d);           chk("R1 select", {32'd0, d}, 64'd0);
        chk("R1 entry5 export", tbl[5*64 +: 64], 64'h0000_0000_0001_0000);
        chk("R1 entry23 export", tbl[23*64 +: 64], 64'h0000_0000_0001_0000);
        win_rd(8'h1A, d);       chk("R1 entry5 low read", {32'd0, d}, 64'h0001_0000);
        win_rd(8'h00, d);       chk("R1 id", {32'd0, d}, 64'd0);
        rd(8'h20, d);           chk("R2 unmapped address", {32'd0, d}, 64'd0);

        // vector table
        for (int k = 0; k < 8; k++) begin
            wr(8'h00, {24'd0, VEC[k][71:64]}, 1'b1);
            rd(8'h00, d);
            chk("R2 select readback", {32'd0, d}, {56'd0, VEC[k][71:64]});
            wr(8'h10, VEC[k][63:32], 1'b1);
            chk("R4 R9 storm pulse target", {40'd0, sclr},
                (VEC[k][71:64] >= 8'h10 && VEC[k][71:64] < 8'h40) ?
                    (64'd1 << ((VEC[k][71:64] - 8'h10) >> 1)) : 64'd0);
            rd(8'h10, d);
            chk("R3 R4 R5 R6 window read", {32'd0, d}, {32'd0, VEC[k][31:0]});
        end

        chk("R11 entry0 export", tbl[0 +: 64], 64'hFF00_0000_0000_A031);
        chk("R3 entry15 low untouched", tbl[15*64 +: 64], 64'h1234_5678_0001_0000);
        win_rd(8'h00, d);       chk("R4 id after ignored write", {32'd0, d}, 64'h0F00_0000);

        // R7 status bits driven from hardware
        wr(8'h00, 32'h16, 1'b1);
        wr(8'h10, 32'h0000_8040, 1'b1);
        @(negedge clk); rset[3] = 1'b1;
        @(negedge clk); rset[3] = 1'b0;
        rd(8'h10, d);           chk("R7 rirr set", {32'd0, d}, 64'h0000_C040);
        wr(8'h10, 32'h0000_8041, 1'b1);
        chk("R9 storm pin3", {40'd0, sclr}, 64'h8);
        @(negedge clk);
        chk("R9 storm single cycle", {40'd0, sclr}, 64'd0);
        rd(8'h10, d);           chk("R7 rirr kept on write", {32'd0, d}, 64'h0000_C041);
        wr(8'h00, 32'h17, 1'b1);
        wr(8'h10, 32'hAB00_0000, 1'b1);
        chk("R7 rirr kept on upper write", tbl[3*64 +: 64], 64'hAB00_0000_0000_C041);
        wr(8'h00, 32'h16, 1'b1);
        busy[3] = 1'b1;
        @(negedge clk);
        rd(8'h10, d);           chk("R7 busy bit", {32'd0, d}, 64'h0000_D041);
        busy[3] = 1'b0;
        @(negedge clk); rclr[3] = 1'b1; rset[3] = 1'b1;
        @(negedge clk); rclr[3] = 1'b0; rset[3] = 1'b0;
        chk("R7 clear wins", {63'd0, tbl[3*64 + 14]}, 64'd0);

        // R8 switch to edge clears remote IRR
        @(negedge clk); rset[3] = 1'b1;
        @(negedge clk); rset[3] = 1'b0;
        chk("R8 precondition", {63'd0, tbl[3*64 + 14]}, 64'd1);
        wr(8'h10, 32'h0000_4041, 1'b1);
        rd(8'h10, d);           chk("R8 edge clears rirr", {32'd0, d}, 64'h0000_0041);

        // R10 EOI
        wr(8'h40, 32'h0000_0177, 1'b1);
        chk("R10 eoi strobe", {55'd0, ev, evec}, {55'd0, 1'b1, 8'h77});
        chk("R10 old version no strobe", {63'd0, ev_old}, 64'd0);
        @(negedge clk);
        chk("R10 strobe one cycle", {63'd0, ev}, 64'd0);
        wr(8'h40, 32'h0000_0055, 1'b0);
        chk("R10 narrow write ignored", {63'd0, ev}, 64'd0);
        bus_addr = 8'h10;
        wr(8'h00, 32'h01, 1'b1);
        rd(8'h10, d);           chk("R5 old version code", {32'd0, rdata_old}, 64'h0017_0011);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule